// File: doc/BRIEF.md
# Circular-Pipeline Longest Prefix Lookup

This block resolves a 32-bit IPv4 destination address to a route result. It walks a three-level multibit trie stored in one shared table memory. The first level has 2^16 entries and the two lower levels use 8-bit strides. A lookup may start only after it has drawn an order token from a local pool. Its first table read is then issued, and a tracking FIFO records the token and the 16 low address bits that have not yet been consumed.

Each word that comes back from the memory either finishes the lookup or sends it around the loop for one more read. A finished lookup leaves on the exit port as a (token, result) pair, and a downstream reorder stage uses the pair to restore arrival order. That stage returns one token credit per slot it frees. Entry and leaf exit can happen in the same cycle, so a stream of short lookups runs at one address per clock. The memory port is latency-insensitive: a request with a ready, plus a response valid that the block acknowledges when it consumes the word.

Top module: `lpm_circ_lookup`

## Requirements
- R1: After reset, `out_valid` and `mem_req_valid` are low and `in_ready` is high while `mem_req_ready` is high.
- R2: In a cycle where an address is accepted (`in_valid && in_ready`), the block issues a memory request at index `in_addr[31:16]` in that same cycle.
- R3: A table word with bit 31 clear is a pointer held in its low `MEM_AW` bits. The next request goes to pointer plus `in_addr[15:8]` after a first-level read, and to pointer plus `in_addr[7:0]` after a second-level read.
- R4: A word with bit 31 set is a leaf. The block acknowledges it in the cycle it is offered, and one cycle later `out_valid` pulses with `out_result` equal to word bits [30:0] and `out_token` equal to the token of that lookup.
- R5: A third-level word always ends the lookup, and its bits [30:0] are the result whatever bit 31 holds.
- R6: Tokens are issued in entry order, starting at 0 and wrapping after `NUM_TOK-1`. With no token free, `in_ready` is low, and each `tok_ret` pulse frees one token.
- R7: When `FIFO_DEPTH` lookups are in flight, `in_ready` is low.
- R8: While a pointer word below level 3 is offered and `mem_req_ready` is high, the memory port carries the recirculating request, the word is acknowledged, and `in_ready` is low.
- R9: A new entry and a leaf exit can happen in the same cycle. `in_ready` is high whenever a token is free, fewer than `FIFO_DEPTH` lookups are in flight, `mem_req_ready` is high and no recirculation is pending, so back-to-back single-read lookups enter one per cycle.
- R10: A pointer word below level 3 that is offered while `mem_req_ready` is low is not acknowledged, and it stays pending.
- R11: Across a sweep of addresses, every result equals the longest matching prefix in the stored table, whatever the stalls on the memory request port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An address is offered |
| in_addr | input | 32 | Destination address |
| in_ready | output | 1 | Address accepted this cycle if `in_valid` |
| tok_ret | input | 1 | One token credit returned by the reorder stage |
| out_valid | output | 1 | Finished lookup on the exit port |
| out_token | output | TOK_W | Order token of the finished lookup |
| out_result | output | 31 | Route result |
| mem_req_valid | output | 1 | Table read request |
| mem_req_addr | output | MEM_AW | Table read index |
| mem_req_ready | input | 1 | Memory accepts a request |
| mem_rsp_valid | input | 1 | Memory response word offered |
| mem_rsp_data | input | 32 | Response word |
| mem_rsp_deq | output | 1 | Response word consumed |

## Verification
If the tracking FIFO loses its pairing of token, remaining bits and level, the fault appears at the ports when the next word is consumed. It shows either as a wrong recirculation index on `mem_req_addr` in that same cycle, or as a wrong (token, result) pair one cycle later. A drifting token count or FIFO count shows as `in_ready` having the wrong value in the very cycle the limit is reached, checked against counts kept from port events. A dead cycle between exit and entry shows as lost throughput on a stream of single-read lookups. A wrong stride or level shows as a result that differs from an independent longest-prefix search within a few memory latencies.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int IP_W     = 32;
  localparam int WORD_W   = 32;
  localparam int LEAF_BIT = 31;
  localparam int ROOT_W   = 16;
  localparam int STRIDE   = 8;
  localparam int REM_W    = IP_W - ROOT_W;
  localparam int RES_W    = WORD_W - 1;

  typedef enum logic [1:0] {
    LV_ROOT = 2'd1,
    LV_MID  = 2'd2,
    LV_LAST = 2'd3
  } lvl_e;
endpackage

// File: rtl/lpm_token_pool.sv
module lpm_token_pool #(
  parameter int NUM_TOK = 16,
  localparam int TOK_W = (NUM_TOK > 1) ? $clog2(NUM_TOK) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             give,
  output logic             avail,
  output logic [TOK_W-1:0] tok
);
  localparam int CNT_W = $clog2(NUM_TOK + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NUM_TOK);
  localparam logic [TOK_W-1:0] LAST_TOK = TOK_W'(NUM_TOK - 1);

  logic [CNT_W-1:0] free_q;
  logic [TOK_W-1:0] next_q;
  logic             give_ok;

  assign avail   = (free_q != '0);
  assign tok     = next_q;
  assign give_ok = give && (free_q != FULL_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      free_q <= FULL_CNT;
      next_q <= '0;
    end else begin
      if (take && !give_ok)      free_q <= free_q - 1'b1;
      else if (!take && give_ok) free_q <= free_q + 1'b1;
      if (take) next_q <= (next_q == LAST_TOK) ? '0 : next_q + 1'b1;
    end
  end
endmodule

// File: rtl/lpm_track_fifo.sv
module lpm_track_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 20,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          full,
  output logic [CW-1:0] level
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  assign head  = store[rd_q];
  assign full  = (cnt_q == CW'(DEPTH));
  assign level = cnt_q;

  always_ff @(posedge clk) begin
    if (push) store[wr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      if (push && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/lpm_walk_step.sv
module lpm_walk_step
  import lpm_pkg::*;
#(
  parameter int MEM_AW = 18
) (
  input  logic [WORD_W-1:0] word,
  input  logic [REM_W-1:0]  rem,
  input  logic [1:0]        lvl,
  output logic              is_final,
  output logic [RES_W-1:0]  result,
  output logic [MEM_AW-1:0] next_addr,
  output logic [REM_W-1:0]  next_rem,
  output logic [1:0]        next_lvl
);
  logic [STRIDE-1:0] slice;

  assign slice     = rem[REM_W-1 -: STRIDE];
  assign is_final  = word[LEAF_BIT] || (lvl == LV_LAST);
  assign result    = word[RES_W-1:0];
  assign next_addr = word[MEM_AW-1:0] + MEM_AW'(slice);
  assign next_rem  = {rem[REM_W-STRIDE-1:0], {STRIDE{1'b0}}};
  assign next_lvl  = lvl + 2'd1;
endmodule

// File: rtl/lpm_circ_lookup.sv
module lpm_circ_lookup
  import lpm_pkg::*;
#(
  parameter int NUM_TOK    = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int MEM_AW     = 18,
  localparam int TOK_W = (NUM_TOK > 1) ? $clog2(NUM_TOK) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       in_addr,
  output logic              in_ready,
  input  logic              tok_ret,
  output logic              out_valid,
  output logic [TOK_W-1:0]  out_token,
  output logic [30:0]       out_result,
  output logic              mem_req_valid,
  output logic [MEM_AW-1:0] mem_req_addr,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              mem_rsp_deq
);
  localparam int ENT_W = TOK_W + REM_W + 2;
  localparam int CW    = $clog2(FIFO_DEPTH + 1);

  logic             tok_avail;
  logic [TOK_W-1:0] new_tok;
  logic [ENT_W-1:0] head_ent, push_ent;
  logic             fifo_full;
  logic [CW-1:0]    fifo_cnt;
  logic [TOK_W-1:0] h_tok;
  logic [REM_W-1:0] h_rem;
  logic [1:0]       h_lvl;
  logic             w_final;
  logic [RES_W-1:0] w_result;
  logic [MEM_AW-1:0] w_next_addr;
  logic [REM_W-1:0] w_next_rem;
  logic [1:0]       w_next_lvl;
  logic             rsp_more, do_exit, do_recirc, do_enter;

  assign {h_tok, h_rem, h_lvl} = head_ent;

  lpm_token_pool #(.NUM_TOK(NUM_TOK)) u_pool (
    .clk   (clk),
    .rst   (rst),
    .take  (do_enter),
    .give  (tok_ret),
    .avail (tok_avail),
    .tok   (new_tok)
  );

  lpm_walk_step #(.MEM_AW(MEM_AW)) u_step (
    .word      (mem_rsp_data),
    .rem       (h_rem),
    .lvl       (h_lvl),
    .is_final  (w_final),
    .result    (w_result),
    .next_addr (w_next_addr),
    .next_rem  (w_next_rem),
    .next_lvl  (w_next_lvl)
  );

  // Response side: a final word leaves, a pointer word goes round again.
  assign rsp_more    = mem_rsp_valid && !w_final;
  assign do_exit     = mem_rsp_valid && w_final;
  assign do_recirc   = rsp_more && mem_req_ready;
  assign mem_rsp_deq = do_exit || do_recirc;

  // Entry yields the shared request port to a pending recirculation.
  assign in_ready = tok_avail && !fifo_full && mem_req_ready && !rsp_more;
  assign do_enter = in_valid && in_ready;

  assign mem_req_valid = do_enter || do_recirc;
  assign mem_req_addr  = do_recirc ? w_next_addr : MEM_AW'(in_addr[31:16]);

  assign push_ent = do_recirc ? {h_tok, w_next_rem, w_next_lvl}
                              : {new_tok, in_addr[REM_W-1:0], LV_ROOT};

  lpm_track_fifo #(.DEPTH(FIFO_DEPTH), .W(ENT_W)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (do_enter || do_recirc),
    .push_data (push_ent),
    .pop       (mem_rsp_deq),
    .head      (head_ent),
    .full      (fifo_full),
    .level     (fifo_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_token  <= '0;
      out_result <= '0;
    end else begin
      out_valid <= do_exit;
      if (do_exit) begin
        out_token  <= h_tok;
        out_result <= w_result;
      end
    end
  end
endmodule

// File: rtl/lpm_circ_lookup_chk.sv
module lpm_circ_lookup_chk #(
  parameter int FIFO_DEPTH = 8,
  parameter int MEM_AW     = 18,
  parameter int CW         = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [31:0]       in_addr,
  input logic              in_ready,
  input logic              out_valid,
  input logic [30:0]       out_result,
  input logic              mem_req_valid,
  input logic [MEM_AW-1:0] mem_req_addr,
  input logic              mem_req_ready,
  input logic              mem_rsp_valid,
  input logic [31:0]       mem_rsp_data,
  input logic              mem_rsp_deq,
  input logic [1:0]        h_lvl,
  input logic [CW-1:0]     fifo_cnt
);
  a_r2_root_index: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |-> (mem_req_valid && mem_req_addr == MEM_AW'(in_addr[31:16])));

  a_r4_leaf_exit: assert property (@(posedge clk) disable iff (rst)
    (mem_rsp_valid && mem_rsp_deq && mem_rsp_data[31])
      |=> (out_valid && out_result == $past(mem_rsp_data[30:0])));

  a_r7_fifo_bound: assert property (@(posedge clk) disable iff (rst)
    fifo_cnt <= CW'(FIFO_DEPTH));

  a_r8_recirc_wins: assert property (@(posedge clk) disable iff (rst)
    (mem_rsp_valid && !mem_rsp_data[31] && h_lvl != 2'd3) |-> !in_ready);

  a_r10_hold_pending: assert property (@(posedge clk) disable iff (rst)
    (mem_rsp_valid && !mem_rsp_data[31] && h_lvl != 2'd3 && !mem_req_ready) |-> !mem_rsp_deq);

  a_r9_req_needs_ready: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> mem_req_ready);
endmodule

bind lpm_circ_lookup lpm_circ_lookup_chk #(
  .FIFO_DEPTH (FIFO_DEPTH),
  .MEM_AW     (MEM_AW),
  .CW         ($clog2(FIFO_DEPTH + 1))
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .in_addr       (in_addr),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_result    (out_result),
  .mem_req_valid (mem_req_valid),
  .mem_req_addr  (mem_req_addr),
  .mem_req_ready (mem_req_ready),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_data  (mem_rsp_data),
  .mem_rsp_deq   (mem_rsp_deq),
  .h_lvl         (h_lvl),
  .fifo_cnt      (fifo_cnt)
);

// File: tb/lpm_circ_lookup_bench.sv
module lpm_circ_lookup_bench;
  localparam int NT  = 16;
  localparam int FD  = 8;
  localparam int AW  = 18;
  localparam int LAT = 3;
  localparam int TW  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          in_valid = 1'b0;
  logic [31:0]   in_addr = '0;
  logic          in_ready;
  logic          tok_ret;
  logic          out_valid;
  logic [TW-1:0] out_token;
  logic [30:0]   out_result;
  logic          mem_req_valid;
  logic [AW-1:0] mem_req_addr;
  logic          mem_req_ready;
  logic          mem_rsp_valid;
  logic [31:0]   mem_rsp_data;
  logic          mem_rsp_deq;

  lpm_circ_lookup #(.NUM_TOK(NT), .FIFO_DEPTH(FD), .MEM_AW(AW)) u_lpm_circ_lookup (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr), .in_ready(in_ready),
    .tok_ret(tok_ret), .out_valid(out_valid), .out_token(out_token), .out_result(out_result),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_deq(mem_rsp_deq)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Table contents, computed from the address.
  function automatic logic [31:0] mem_fn(input logic [AW-1:0] a);
    logic [7:0] b;
    b = a[7:0];
    if (a < 18'h10000) begin
      if (a[15:0] == 16'h070E) return 32'h0001_0200;
      if (a[15:0] == 16'h0A12) return 32'h0001_0000;
      if (a[15:8] == 8'd5)     return 32'h8000_0005;
      return 32'h8000_0000;
    end
    case (a[17:8])
      10'h100: return (b == 8'd200) ? 32'h0001_0100 : (b == 8'd201) ? 32'h8000_0006 : 32'h8000_0000;
      10'h102: return (b == 8'd7) ? 32'h0001_0300 : 32'h8000_0001;
      10'h101: return (b == 8'd5) ? 32'h8000_0004 : 32'h8000_0003;
      10'h103: return (b == 8'd3) ? 32'h8000_0002 : (b == 8'd9) ? 32'h0000_0077 : 32'h8000_0001;
      default: return 32'h8000_0000;
    endcase
  endfunction

  // Independent longest-prefix search over the prefix list.
  function automatic logic [30:0] ref_lpm(input logic [31:0] ip);
    if (ip == {8'd7, 8'd14, 8'd7, 8'd3})   return 31'h2;
    if (ip == {8'd7, 8'd14, 8'd7, 8'd9})   return 31'h77;
    if (ip == {8'd10, 8'd18, 8'd200, 8'd5}) return 31'h4;
    if (ip[31:8] == {8'd10, 8'd18, 8'd200}) return 31'h3;
    if (ip[31:8] == {8'd10, 8'd18, 8'd201}) return 31'h6;
    if (ip[31:16] == {8'd7, 8'd14})         return 31'h1;
    if (ip[31:24] == 8'd5)                  return 31'h5;
    return 31'h0;
  endfunction

  function automatic logic [7:0] next_slice(input logic [31:0] ip, input int lvl);
    return (lvl == 1) ? ip[15:8] : ip[7:0];
  endfunction

  // Memory model: fixed latency, in-order response queue.
  logic [31:0] q_data [16];
  logic [31:0] q_ip   [16];
  int          q_lvl  [16];
  int          q_due  [16];
  logic [3:0]  m_hd, m_tl;
  int          m_cnt, cyc;
  logic        freeze = 1'b0;
  logic        throttle = 1'b0;
  logic [7:0]  lfsr;
  logic        m_rdy;

  assign mem_req_ready = m_rdy;
  assign mem_rsp_valid = (m_cnt != 0) && !freeze && (cyc >= q_due[m_hd]);
  assign mem_rsp_data  = q_data[m_hd];

  function automatic bit head_more();
    return !q_data[m_hd][31] && q_lvl[m_hd] != 3;
  endfunction

  always @(posedge clk) begin
    bit pop, pushq;
    cyc  <= cyc + 1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    m_rdy <= !throttle || lfsr[0] || lfsr[3];
    if (rst) begin
      m_hd <= '0; m_tl <= '0; m_cnt <= 0; cyc <= 0; lfsr <= 8'h5A; m_rdy <= 1'b1;
    end else begin
      pop   = mem_rsp_valid && mem_rsp_deq;
      pushq = mem_req_valid && mem_req_ready;
      if (pushq) begin
        q_data[m_tl] <= mem_fn(mem_req_addr);
        q_due[m_tl]  <= cyc + LAT;
        if (pop && head_more()) begin
          q_ip[m_tl]  <= q_ip[m_hd];
          q_lvl[m_tl] <= q_lvl[m_hd] + 1;
        end else begin
          q_ip[m_tl]  <= in_addr;
          q_lvl[m_tl] <= 1;
        end
        m_tl <= m_tl + 1'b1;
      end
      if (pop) m_hd <= m_hd + 1'b1;
      m_cnt <= m_cnt + (pushq ? 1 : 0) - (pop ? 1 : 0);
    end
  end

  // Reorder-stage stand-in: returns one credit per finished lookup.
  logic credit_en = 1'b1;
  int   pend;
  always @(posedge clk) begin
    int nxt;
    if (rst) begin
      pend <= 0; tok_ret <= 1'b0;
    end else begin
      nxt = pend + (out_valid ? 1 : 0) - (tok_ret ? 1 : 0);
      pend <= nxt;
      tok_ret <= credit_en && (nxt > 0);
    end
  end

  // Monitor: port-level scoreboard and flow checks.
  logic [31:0]   exp_addr [NT];
  int            ent_cnt = 0, ext_cnt = 0, crd_cnt = 0, rx_cnt = 0;
  logic [TW-1:0] last_tok;
  logic [30:0]   last_res;

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_rsp_valid && head_more()) begin
        chk(!in_ready, "R8", in_ready, 0);
        if (m_rdy) begin
          chk(mem_rsp_deq && mem_req_valid, "R8", {mem_rsp_deq, mem_req_valid}, 3);
          chk(mem_req_addr == AW'(mem_rsp_data[AW-1:0] + AW'(next_slice(q_ip[m_hd], q_lvl[m_hd]))),
              "R3", mem_req_addr, mem_rsp_data[AW-1:0] + next_slice(q_ip[m_hd], q_lvl[m_hd]));
        end else begin
          chk(!mem_rsp_deq, "R10", mem_rsp_deq, 0);
        end
      end else if (ent_cnt - ext_cnt >= FD) begin
        chk(!in_ready, "R7", in_ready, 0);
      end else if (ent_cnt - crd_cnt >= NT) begin
        chk(!in_ready, "R6", in_ready, 0);
      end else if (m_rdy) begin
        chk(in_ready, "R9", in_ready, 1);
      end
      if (mem_rsp_valid && !head_more())
        chk(mem_rsp_deq, "R4", mem_rsp_deq, 1);
      if (in_valid && in_ready) begin
        chk(mem_req_valid && mem_req_addr == AW'(in_addr[31:16]), "R2", mem_req_addr, in_addr[31:16]);
        exp_addr[ent_cnt % NT] = in_addr;
      end
      if (out_valid) begin
        chk(out_result == ref_lpm(exp_addr[out_token]), "R4 R11", out_result, ref_lpm(exp_addr[out_token]));
        last_tok = out_token;
        last_res = out_result;
        rx_cnt++;
      end
      if (in_valid && in_ready) ent_cnt++;
      if (mem_rsp_valid && mem_rsp_deq && !head_more()) ext_cnt++;
      if (tok_ret) crd_cnt++;
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=%0d expected=done", rx_cnt);
    summary();
    $finish;
  end

  task automatic send(input logic [31:0] a);
    in_addr  = a;
    in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic drain();
    in_valid = 1'b0;
    while (rx_cnt != ent_cnt || pend != 0 || tok_ret) @(posedge clk);
    #1;
  endtask

  task automatic serial(input logic [31:0] a, input string tag);
    int idx;
    idx = ent_cnt;
    send(a);
    drain();
    chk(last_tok == TW'(idx % NT), "R6", last_tok, idx % NT);
    chk(last_res == ref_lpm(a), tag, last_res, ref_lpm(a));
  endtask

  initial begin : stim
    int t0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(!out_valid, "R1", out_valid, 0);
    chk(!mem_req_valid, "R1", mem_req_valid, 0);
    chk(in_ready, "R1", in_ready, 1);
    @(posedge clk); #1;

    // Directed single lookups over 1, 2 and 3 reads.
    serial({8'd5, 8'd1, 8'd2, 8'd3}, "R4");
    serial({8'd10, 8'd18, 8'd201, 8'd1}, "R3");
    serial({8'd10, 8'd18, 8'd200, 8'd5}, "R3");
    serial({8'd7, 8'd14, 8'd7, 8'd3}, "R3");
    serial({8'd7, 8'd14, 8'd7, 8'd9}, "R5");
    serial({8'd9, 8'd9, 8'd9, 8'd9}, "R4");

    // Token exhaustion and credit return.
    credit_en = 1'b0;
    for (int k = 0; k < NT; k++) send({8'd5, 8'(k), 8'd0, 8'd0});
    in_valid = 1'b0;
    while (rx_cnt != ent_cnt) @(posedge clk);
    @(negedge clk);
    chk(!in_ready, "R6", in_ready, 0);
    @(posedge clk); #1;
    credit_en = 1'b1;
    drain();
    @(negedge clk);
    chk(in_ready, "R6", in_ready, 1);
    @(posedge clk); #1;

    // In-flight limit with responses withheld.
    freeze = 1'b1;
    for (int k = 0; k < FD; k++) send({8'd5, 8'd7, 8'(k), 8'd1});
    in_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(!in_ready, "R7", in_ready, 0);
    @(posedge clk); #1;
    freeze = 1'b0;
    drain();

    // Back-to-back single-read stream: entry alongside exit.
    t0 = cyc;
    for (int k = 0; k < 32; k++) send({8'd5, 8'(k), 8'(k), 8'd0});
    chk((cyc - t0) <= 34, "R9", cyc - t0, 34);
    drain();

    // Sweeps, first with a free request port, then with stalls.
    for (int pass = 0; pass < 2; pass++) begin
      throttle = (pass == 1);
      for (int k = 0; k < 256; k++) send({8'd7, 8'd14, 8'd7, 8'(k)});
      for (int k = 0; k < 256; k++) send({8'd10, 8'd18, 8'd200, 8'(k)});
      for (int k = 0; k < 256; k++) send({8'd10, 8'd18, 8'(k), 8'd5});
      for (int k = 0; k < 256; k++) send({8'd7, 8'd14, 8'(k), 8'd3});
      for (int k = 0; k < 64; k++) send({8'(k * 4 + 1), 8'(k * 7), 8'(k), 8'(k * 3)});
      drain();
    end
    chk(rx_cnt == ent_cnt, "R11", rx_cnt, ent_cnt);

    summary();
    $finish;
  end
endmodule